// File: doc/BRIEF.md
# Impact-Triggered Capture Controller

This block records a stream of 12-bit samples into a circular on-chip buffer and freezes that record around an impact event. Until an impact occurs, every sample strobe writes the current sample into the next buffer slot, and the oldest entry is overwritten once the buffer has wrapped. An impact is recognised only on the strobe that closes a sampling frame, and only when that sample is strictly greater than a programmable threshold. Writing then continues for a fixed number of further strobes before the buffer freezes. This keeps a short stretch of post-impact data alongside the history that came before it.

From the cycle after the impact, a read-out enable stays high for a fixed number of transmission-window ticks. After the freeze, each window tick streams one stored sample, oldest first, until every valid entry has been sent. When the read-out period ends, the buffer empties and detection re-arms. A separate timer raises a calibration flag after a push-button press and holds it for a fixed number of window ticks. A second press while the flag is high starts that count again.

Top module: `impact_capture`

## Requirements
- R1: While rst_ni is low, impact_o, rd_en_o, rd_valid_o, rd_data_o and cal_o are all 0.
- R2: Outside the frozen read-out phase, each clock cycle with strobe_i high writes sample_i into the next circular slot.
- R3: An impact is detected only when strobe_i and frame_last_i are both high, detection is armed, and sample_i is strictly greater than thresh_i. A sample equal to the threshold, or a high sample on a strobe that does not close a frame, does not trigger.
- R4: impact_o is a single-cycle pulse, high in the cycle after the detecting edge.
- R5: Writing stops after FREEZE_STROBES further strobes following the trigger strobe. The last of those strobes is still written.
- R6: rd_en_o rises together with impact_o and falls after READ_WINDOWS tick_i pulses. A tick in the detecting cycle is not counted.
- R7: After the freeze, each tick_i while rd_en_o is high and entries remain gives a one-cycle rd_valid_o with rd_data_o. The order starts at the oldest stored sample: slot 0 if the buffer never wrapped, otherwise the slot after the newest.
- R8: Samples above the threshold are ignored while rd_en_o is high. When rd_en_o falls, the buffer empties and detection re-arms.
- R9: btn_i passes through two synchronizing flops. A rising edge sets cal_o three cycles after btn_i is first sampled high.
- R10: cal_o clears after CAL_WINDOWS tick_i pulses counted from the last press. A press while cal_o is high restarts the count, and ticks do not move cal_o while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample strobe; sample_i is valid |
| frame_last_i | input | 1 | Marks the strobe that closes a sampling frame |
| sample_i | input | 12 | Sample data |
| thresh_i | input | 12 | Impact threshold |
| tick_i | input | 1 | Transmission-window tick |
| btn_i | input | 1 | Calibration push-button, asynchronous |
| impact_o | output | 1 | Impact detected pulse |
| rd_en_o | output | 1 | Read-out period active |
| rd_valid_o | output | 1 | rd_data_o carries a stored sample |
| rd_data_o | output | 12 | Streamed sample |
| cal_o | output | 1 | Calibration flag |

## Verification
The hardest state to reach is a second capture that freezes before the buffer has wrapped. Here read-out must start at slot 0 and stop early, not stream stale entries. The stimulus holds the sample above threshold across the cycles just after the first read-out ends, so the re-armed detector fires at the very next frame-closing strobe with fewer writes than the depth. Earlier windows place above-threshold samples on a strobe that does not close a frame, at exactly the threshold, and in the middle of a read-out. Calibration presses are spaced so that one lands while the flag is still high.

// File: rtl/impact_capture_pkg.sv
package impact_capture_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_POST  = 2'd1,
    ST_READ  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import impact_capture_pkg::*;
#(
  parameter int SW             = 12,
  parameter int FREEZE_STROBES = 6,
  parameter int READ_WINDOWS   = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          frame_last_i,
  input  logic [SW-1:0] sample_i,
  input  logic [SW-1:0] thresh_i,
  input  logic          tick_i,
  input  logic          left_zero_i,
  output logic          wr_o,
  output logic          freeze_o,
  output logic          clear_o,
  output logic          rd_o,
  output logic          impact_o,
  output logic          rd_en_o
);
  localparam int PCW = $clog2(FREEZE_STROBES + 1);
  localparam int WCW = $clog2(READ_WINDOWS + 1);

  cap_state_e     st_q;
  logic [PCW-1:0] pcnt_q;
  logic [WCW-1:0] wcnt_q;
  logic           trig;

  assign trig     = (st_q == ST_ARMED) && strobe_i && frame_last_i && (sample_i > thresh_i);
  assign clear_o  = (st_q != ST_ARMED) && tick_i && (wcnt_q == WCW'(READ_WINDOWS - 1));
  assign wr_o     = strobe_i && (st_q != ST_READ);
  assign rd_o     = (st_q == ST_READ) && tick_i && !left_zero_i;
  assign freeze_o = (st_q == ST_POST) && strobe_i && (pcnt_q == PCW'(FREEZE_STROBES - 1)) && !clear_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_ARMED;
      pcnt_q   <= '0;
      wcnt_q   <= '0;
      impact_o <= 1'b0;
      rd_en_o  <= 1'b0;
    end else begin
      impact_o <= trig;
      if (clear_o) begin
        st_q    <= ST_ARMED;
        rd_en_o <= 1'b0;
      end else if (trig) begin
        st_q    <= ST_POST;
        pcnt_q  <= '0;
        wcnt_q  <= '0;
        rd_en_o <= 1'b1;
      end else begin
        if (freeze_o)                          st_q   <= ST_READ;
        else if (st_q == ST_POST && strobe_i)  pcnt_q <= pcnt_q + 1'b1;
        if (st_q != ST_ARMED && tick_i)        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/capture_buf.sv
module capture_buf #(
  parameter int SW    = 12,
  parameter int DEPTH = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [SW-1:0] wdata_i,
  input  logic          freeze_i,
  input  logic          clear_i,
  input  logic          rd_i,
  output logic          left_zero_o,
  output logic          rd_valid_o,
  output logic [SW-1:0] rd_data_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [SW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q;
  logic          full_q, full_n;
  logic [LW-1:0] left_q;

  assign wp_n        = wr_i ? ((wp_q == LAST) ? '0 : wp_q + 1'b1) : wp_q;
  assign full_n      = full_q || (wr_i && wp_q == LAST);
  assign left_zero_o = (left_q == '0);

  always_ff @(posedge clk_i) begin
    if (wr_i && !clear_i) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q       <= '0;
      rp_q       <= '0;
      full_q     <= 1'b0;
      left_q     <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else if (clear_i) begin
      wp_q       <= '0;
      full_q     <= 1'b0;
      left_q     <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) begin
        rd_data_o <= mem[rp_q];
        rp_q      <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
        left_q    <= left_q - 1'b1;
      end
      wp_q   <= wp_n;
      full_q <= full_n;
      // oldest entry: slot after newest once wrapped, else slot 0
      if (freeze_i) begin
        rp_q   <= full_n ? wp_n : '0;
        left_q <= full_n ? LW'(DEPTH) : LW'(wp_n);
      end
    end
  end
endmodule

// File: rtl/cal_flag.sv
module cal_flag #(
  parameter int CAL_WINDOWS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  input  logic tick_i,
  output logic cal_o
);
  localparam int CW = $clog2(CAL_WINDOWS + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          press;

  assign press = sync_q[1] && !sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
      cal_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], btn_i};
      if (press) begin
        cal_o <= 1'b1;
        cnt_q <= '0;
      end else if (cal_o && tick_i) begin
        if (cnt_q == CW'(CAL_WINDOWS - 1)) cal_o <= 1'b0;
        else                               cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/impact_capture.sv
module impact_capture #(
  parameter int SW             = 12,
  parameter int DEPTH          = 32,
  parameter int FREEZE_STROBES = 6,
  parameter int READ_WINDOWS   = 40,
  parameter int CAL_WINDOWS    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          frame_last_i,
  input  logic [SW-1:0] sample_i,
  input  logic [SW-1:0] thresh_i,
  input  logic          tick_i,
  input  logic          btn_i,
  output logic          impact_o,
  output logic          rd_en_o,
  output logic          rd_valid_o,
  output logic [SW-1:0] rd_data_o,
  output logic          cal_o
);
  logic wr, freeze, clear, rd, left_zero;

  capture_ctrl #(
    .SW(SW), .FREEZE_STROBES(FREEZE_STROBES), .READ_WINDOWS(READ_WINDOWS)
  ) i_ctrl (
    .clk_i, .rst_ni, .strobe_i, .frame_last_i, .sample_i, .thresh_i, .tick_i,
    .left_zero_i(left_zero), .wr_o(wr), .freeze_o(freeze), .clear_o(clear),
    .rd_o(rd), .impact_o, .rd_en_o
  );

  capture_buf #(.SW(SW), .DEPTH(DEPTH)) i_buf (
    .clk_i, .rst_ni, .wr_i(wr), .wdata_i(sample_i), .freeze_i(freeze),
    .clear_i(clear), .rd_i(rd), .left_zero_o(left_zero), .rd_valid_o, .rd_data_o
  );

  cal_flag #(.CAL_WINDOWS(CAL_WINDOWS)) i_cal (
    .clk_i, .rst_ni, .btn_i, .tick_i, .cal_o
  );
endmodule

// File: rtl/impact_capture_chk.sv
module impact_capture_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic impact_o,
  input logic rd_en_o,
  input logic rd_valid_o,
  input logic cal_o
);
  // R4
  impact_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    impact_o |=> !impact_o);
  // R6
  rd_en_with_impact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_en_o) |-> impact_o);
  // R8
  no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    impact_o |-> !$past(rd_en_o));
  // R7
  valid_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_en_o);
  // R10
  cal_fall_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cal_o) |-> $past(tick_i));
endmodule

bind impact_capture impact_capture_chk i_chk (.*);

// File: tb/test_impact_capture.sv
module test_impact_capture;
  localparam int D = 32, FS = 6, RW = 40, CW = 5, NCYC = 4200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe = 0, last = 0, tick = 0, btn = 0;
  logic [11:0] sample = '0, thresh = 12'h800;
  logic impact, rd_en, rd_valid, cal;
  logic [11:0] rd_data;

  always #10 clk = ~clk;

  impact_capture i_impact_capture (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .frame_last_i(last),
    .sample_i(sample), .thresh_i(thresh), .tick_i(tick), .btn_i(btn),
    .impact_o(impact), .rd_en_o(rd_en), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .cal_o(cal)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int mst = 0, wp = 0, rptr = 0, rleft = 0, pcnt = 0, wcnt = 0, ccnt = 0;
  int mem [D];
  bit full = 0, m_imp = 0, m_rden = 0, m_rval = 0, m_cal = 0, s1 = 0, s2 = 0, s3 = 0;
  int m_rdat = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit trig, ending, wr, rd, frz, press;
    int old_st;
    old_st = mst;
    trig   = (mst == 0) && strobe && last && (int'(sample) > int'(thresh));
    ending = (mst != 0) && tick && (wcnt == RW - 1);
    wr     = strobe && (mst != 2);
    rd     = (mst == 2) && tick && (rleft != 0);
    frz    = (mst == 1) && strobe && (pcnt == FS - 1) && !ending;
    m_imp  = trig;
    if (ending) begin
      wp = 0; full = 0; rleft = 0; m_rval = 0;
    end else begin
      m_rval = rd;
      if (rd) begin m_rdat = mem[rptr]; rptr = (rptr + 1) % D; rleft--; end
      if (wr) begin mem[wp] = int'(sample); if (wp == D - 1) full = 1; wp = (wp + 1) % D; end
      if (frz) begin rptr = full ? wp : 0; rleft = full ? D : wp; end
    end
    if (ending) begin mst = 0; m_rden = 0; end
    else if (trig) begin mst = 1; pcnt = 0; wcnt = 0; m_rden = 1; end
    else begin
      if (frz) mst = 2;
      else if (old_st == 1 && strobe) pcnt++;
      if (old_st != 0 && tick) wcnt++;
    end
    press = s2 && !s3;
    if (press) begin m_cal = 1; ccnt = 0; end
    else if (m_cal && tick) begin
      if (ccnt == CW - 1) m_cal = 0; else ccnt++;
    end
    s3 = s2; s2 = s1; s1 = btn;
  endtask

  function automatic bit hi_at(input int c);
    return (c >= 400 && c < 404) || (c >= 700 && c < 704) ||
           (c >= 1020 && c < 1024) || (c >= 2200 && c < 2400);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 impact_o", int'(impact), 0);
    chk("R1 rd_en_o", int'(rd_en), 0);
    chk("R1 rd_valid_o", int'(rd_valid), 0);
    chk("R1 rd_data_o", int'(rd_data), 0);
    chk("R1 cal_o", int'(cal), 0);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      // R3 R4 impact pulse; R6 R8 read-out window
      chk("R3 R4 impact_o", int'(impact), int'(m_imp));
      chk("R6 R8 rd_en_o", int'(rd_en), int'(m_rden));
      // R2 R5 R7 streamed contents and order
      chk("R7 rd_valid_o", int'(rd_valid), int'(m_rval));
      if (m_rval) chk("R2 R5 R7 rd_data_o", int'(rd_data), m_rdat);
      // R9 R10 calibration flag
      chk("R9 R10 cal_o", int'(cal), int'(m_cal));
      strobe = (c % 4 == 0);
      last   = strobe && (c % 64 == 60);
      tick   = (c > 0) && (c % 37 == 0);
      btn    = (c >= 100 && c < 110) || (c >= 250 && c < 256) || (c >= 3000 && c < 3010);
      if (c == 316)      sample = 12'h800;   // equal to threshold: R3 no trigger
      else if (hi_at(c)) sample = 12'hA00;
      else               sample = 12'((c * 7) % 1024);
      @(posedge clk);
      model_step();
    end
    summary();
  end

  initial begin
    repeat (NCYC + 200) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule